// File: doc/BRIEF.md
# Thermostat Alert with Consecutive-Fault Filter

This block watches a stream of signed temperature results and decides when a thermal alert should be raised or released. Each time a conversion completes, the sensor core presents a 13-bit two's-complement result with a one-cycle valid strobe. The block compares that result against a high limit and a low limit, both held elsewhere in the same format. It acts only after a programmable number of consecutive faulting results, which filters out noise.

Two behaviours are selectable. In comparator mode the alert follows a thermostat with hysteresis: it turns on at or above the high limit and off below the low limit. In interrupt mode the alert latches until software clears it. The clear comes from a register read, a won alert-response arbitration, or entry to shutdown. After each clear the block waits for the opposite condition before it alerts again. A polarity input sets the pin level and the read-back status bit. A cause output reports whether the latched event was a high or a low crossing. A general-call reset returns all state to the idle comparator condition.

Top module: `thermo_alert`

## Requirements
- R1: The fault-count select `fq_sel` values 0, 1, 2 and 3 require 1, 2, 4 and 6 consecutive faulting results before a change. A non-faulting result restarts the count from zero.
- R2: In comparator mode (`intr_mode`=0) the alert becomes active after the selected number of results that are greater than or equal to `lim_hi`.
- R3: Once the comparator has tripped, it becomes inactive after the selected number of results strictly below `lim_lo`.
- R4: In interrupt mode (`intr_mode`=1) the alert becomes active after the selected number of results at or above `lim_hi`. It then stays active, ignoring further results, until `clr_read`, `clr_resp_won` or `clr_shutdown` is pulsed.
- R5: In interrupt mode, after a clear that followed a high-limit alert, the next alert needs the selected number of results below `lim_lo`. The alert after that needs results at or above `lim_hi` again, and the two alternate from then on.
- R6: With `pol`=0, `alert_pin` is low when active and high when inactive. With `pol`=1 the pin is high when active.
- R7: With `pol`=0, `status_bit` reads 1 until the comparator condition trips and 0 while it is tripped. With `pol`=1 it is inverted. Its value depends only on the comparator condition, whatever `intr_mode` is.
- R8: `cause_hi` is 1 when the latched interrupt was caused by the high limit and 0 when it was caused by the low limit. In comparator mode it equals the tripped state.
- R9: `gc_reset` clears the alert, the comparator condition and both fault counts, and returns to the comparator state. Leaving interrupt mode also discards interrupt state, so that re-entering interrupt mode arms for the high limit.
- R10: Comparisons are signed over all 13 bits. A result of 0x0000 is at or above a limit of 0x1FF0 (-1 °C at 0.0625 °C per count).
- R11: A clear pulse in the same cycle as a result makes the interrupt path ignore that result, while the comparator path still counts it. All outputs are registered effects of a result, a clear, a general-call reset or a change of `pol` or `intr_mode`, and of nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_temp | input | 13 | Signed result, 0.0625 °C per count |
| lim_hi | input | 13 | Signed high limit |
| lim_lo | input | 13 | Signed low limit |
| fq_sel | input | 2 | Consecutive-fault count select |
| intr_mode | input | 1 | 0 comparator, 1 latched interrupt |
| pol | input | 1 | Alert polarity, 1 = active high |
| clr_read | input | 1 | Pulse: a register was read |
| clr_resp_won | input | 1 | Pulse: alert-response arbitration won |
| clr_shutdown | input | 1 | Pulse: shutdown entered |
| gc_reset | input | 1 | Pulse: general-call reset |
| alert_pin | output | 1 | Alert output level |
| status_bit | output | 1 | Comparator status as read back |
| cause_hi | output | 1 | Cause of alert, 1 = high limit |

## Verification
The single-result trip and release properties assume that `lim_lo` is not above `lim_hi`. Without that ordering, a result can sit above the high limit and below the low limit at once, and hysteresis has no meaning. The properties also assume that clear and reset inputs are single-cycle pulses sampled on the clock. The directed stimulus sets the limits as an ordered pair. The randomized phase draws the high limit first and places the low limit a random distance beneath it. Result values are spread around both limits, so that both crossings and the restarts of the fault count occur often.

// File: rtl/thermo_alert.sv
module thermo_alert #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [TW-1:0] res_temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic [1:0]    fq_sel,
  input  logic          intr_mode,
  input  logic          pol,
  input  logic          clr_read,
  input  logic          clr_resp_won,
  input  logic          clr_shutdown,
  input  logic          gc_reset,
  output logic          alert_pin,
  output logic          status_bit,
  output logic          cause_hi
);
  localparam int CW = 3;

  logic          cmp_trip, int_act, int_arm_hi, int_cause;
  logic [CW-1:0] cmp_cnt, int_cnt, need;

  always_comb begin
    case (fq_sel)
      2'd0:    need = CW'(1);
      2'd1:    need = CW'(2);
      2'd2:    need = CW'(4);
      default: need = CW'(6);
    endcase
  end

  wire hi_hit    = $signed(res_temp) >= $signed(lim_hi);
  wire lo_hit    = $signed(res_temp) <  $signed(lim_lo);
  wire cmp_fault = cmp_trip   ? lo_hit : hi_hit;
  wire int_fault = int_arm_hi ? hi_hit : lo_hit;
  wire int_clr   = clr_read | clr_resp_won | clr_shutdown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_trip <= 1'b0; cmp_cnt <= '0;
      int_act <= 1'b0; int_arm_hi <= 1'b1; int_cause <= 1'b0; int_cnt <= '0;
    end else if (gc_reset) begin
      cmp_trip <= 1'b0; cmp_cnt <= '0;
      int_act <= 1'b0; int_arm_hi <= 1'b1; int_cause <= 1'b0; int_cnt <= '0;
    end else begin
      if (res_valid) begin
        if (!cmp_fault)
          cmp_cnt <= '0;
        else if (cmp_cnt + CW'(1) >= need) begin
          cmp_trip <= ~cmp_trip;
          cmp_cnt  <= '0;
        end else
          cmp_cnt <= cmp_cnt + CW'(1);
      end

      if (!intr_mode) begin
        int_act <= 1'b0; int_arm_hi <= 1'b1; int_cause <= 1'b0; int_cnt <= '0;
      end else if (int_clr) begin
        int_act <= 1'b0;
        int_cnt <= '0;
      end else if (res_valid && !int_act) begin
        if (!int_fault)
          int_cnt <= '0;
        else if (int_cnt + CW'(1) >= need) begin
          int_act    <= 1'b1;
          int_cause  <= int_arm_hi;
          int_arm_hi <= ~int_arm_hi;
          int_cnt    <= '0;
        end else
          int_cnt <= int_cnt + CW'(1);
      end
    end
  end

  wire active = intr_mode ? int_act : cmp_trip;
  assign alert_pin  = pol ? active : ~active;
  assign status_bit = pol ? cmp_trip : ~cmp_trip;
  assign cause_hi   = intr_mode ? int_cause : cmp_trip;
endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk #(
  parameter int TW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic [TW-1:0] res_temp,
  input logic [TW-1:0] lim_hi,
  input logic [TW-1:0] lim_lo,
  input logic [1:0]    fq_sel,
  input logic          intr_mode,
  input logic          pol,
  input logic          clr_read,
  input logic          clr_resp_won,
  input logic          clr_shutdown,
  input logic          gc_reset,
  input logic          alert_pin,
  input logic          status_bit,
  input logic          cause_hi
);
  wire ordered = $signed(lim_lo) <= $signed(lim_hi);

  // R9
  p_gc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (alert_pin == !pol) && (status_bit == !pol));

  // R4
  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_mode && (clr_read || clr_resp_won || clr_shutdown) && !gc_reset)
      |=> (!intr_mode || alert_pin == !pol));

  // R2
  p_single_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && fq_sel == 2'd0 && !gc_reset && ordered &&
     $signed(res_temp) >= $signed(lim_hi)) |=> ((status_bit ^ pol) == 1'b0));

  // R3
  p_single_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && fq_sel == 2'd0 && !gc_reset && ordered &&
     $signed(res_temp) < $signed(lim_lo)) |=> ((status_bit ^ pol) == 1'b1));

  // R11
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !gc_reset) |=> ((status_bit ^ pol) == $past(status_bit ^ pol)));

  // R7
  p_pin_tracks_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_mode |-> (alert_pin == status_bit));

  // R8
  p_cmp_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_mode |-> (cause_hi == !(status_bit ^ pol)));
endmodule

bind thermo_alert thermo_alert_chk #(.TW(TW)) u_chk (.*);

// File: tb/sim_thermo_alert.sv
module sim_thermo_alert;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic signed [12:0] res_temp = '0, lim_hi = 13'sh0500, lim_lo = 13'sh04B0;
  logic [1:0] fq_sel = 2'd0;
  logic intr_mode = 1'b0, pol = 1'b0;
  logic clr_read = 1'b0, clr_resp_won = 1'b0, clr_shutdown = 1'b0, gc_reset = 1'b0;
  logic alert_pin, status_bit, cause_hi;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  thermo_alert u0 (.*);

  // behavioural reference
  int m_trip, m_ccnt, m_iact, m_arm, m_icnt, m_cause;
  int need_tab[4] = '{1, 2, 4, 6};

  task automatic m_clear_all();
    m_trip = 0; m_ccnt = 0; m_iact = 0; m_arm = 1; m_icnt = 0; m_cause = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || gc_reset) m_clear_all();
    else begin
      int n, t, hi, lo;
      bit f;
      n = need_tab[fq_sel]; t = int'(res_temp); hi = int'(lim_hi); lo = int'(lim_lo);
      if (res_valid) begin
        f = m_trip ? (t < lo) : (t >= hi);
        if (f) begin
          m_ccnt++;
          if (m_ccnt >= n) begin m_trip = !m_trip; m_ccnt = 0; end
        end else m_ccnt = 0;
      end
      if (!intr_mode) begin m_iact = 0; m_arm = 1; m_icnt = 0; m_cause = 0; end
      else if (clr_read || clr_resp_won || clr_shutdown) begin m_iact = 0; m_icnt = 0; end
      else if (res_valid && !m_iact) begin
        f = m_arm ? (t >= hi) : (t < lo);
        if (f) begin
          m_icnt++;
          if (m_icnt >= n) begin m_iact = 1; m_cause = m_arm; m_arm = !m_arm; m_icnt = 0; end
        end else m_icnt = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit act;
    act = intr_mode ? m_iact[0] : m_trip[0];
    chk(cur_req, "alert_pin", alert_pin, pol ? act : !act);
    chk(cur_req, "status_bit", status_bit, pol ? m_trip[0] : !m_trip[0]);
    chk(cur_req, "cause_hi", cause_hi, intr_mode ? m_cause[0] : m_trip[0]);
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic result(input logic signed [12:0] t);
    res_valid = 1'b1; res_temp = t; tick();
    res_valid = 1'b0; tick();
  endtask

  task automatic pulse(ref logic s); s = 1'b1; tick(); s = 1'b0; tick(); endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick(); rst_n = 1'b1; tick();
    @(negedge clk);
    chk("R6", "reset pin", alert_pin, 1'b1);
    chk("R7", "reset status", status_bit, 1'b1);
    tick();

    // R1 / R2: four faults needed, a break restarts the count
    cur_req = "R1"; fq_sel = 2'd2;
    repeat (3) result(13'sh0500);
    result(13'sh0100);
    repeat (3) result(13'sh0520);
    chk("R1", "after broken run", alert_pin, 1'b1);
    cur_req = "R2";
    result(13'sh0500);
    chk("R2", "comparator trip", alert_pin, 1'b0);

    // R3: release below low limit; equal to low is not below
    cur_req = "R3";
    result(13'sh04B0);
    repeat (3) result(13'sh0400);
    chk("R3", "not yet released", alert_pin, 1'b0);
    result(13'sh0400);
    chk("R3", "released", alert_pin, 1'b1);

    // R10: signed limits
    cur_req = "R10"; fq_sel = 2'd0; lim_hi = 13'sh1FF0; lim_lo = 13'sh1F00;
    result(13'sh0000);
    chk("R10", "0 >= -1 trips", status_bit, 1'b0);
    result(13'sh1E00);
    chk("R10", "-32 < -16 releases", status_bit, 1'b1);

    // R6 / R7 polarity inverted
    cur_req = "R6"; pol = 1'b1; tick();
    result(13'sh0010);
    chk("R6", "active high pin", alert_pin, 1'b1);
    chk("R7", "inverted status", status_bit, 1'b1);
    result(13'sh1E00);
    pol = 1'b0; lim_hi = 13'sh0500; lim_lo = 13'sh04B0; tick();

    // R4 / R5 / R8 interrupt cycle
    cur_req = "R4"; intr_mode = 1'b1; fq_sel = 2'd1; tick();
    repeat (2) result(13'sh0600);
    chk("R4", "interrupt set", alert_pin, 1'b0);
    chk("R8", "cause high", cause_hi, 1'b1);
    repeat (3) result(13'sh0100);
    chk("R4", "latched through lows", alert_pin, 1'b0);
    pulse(clr_read);
    chk("R4", "read clears", alert_pin, 1'b1);
    cur_req = "R5";
    repeat (2) result(13'sh0600);
    chk("R5", "high ignored after clear", alert_pin, 1'b1);
    chk("R7", "status independent of mode", status_bit, 1'b0);
    repeat (2) result(13'sh0100);
    chk("R5", "low alert", alert_pin, 1'b0);
    chk("R8", "cause low", cause_hi, 1'b0);
    pulse(clr_resp_won);
    repeat (2) result(13'sh0600);
    chk("R5", "high alert again", alert_pin, 1'b0);
    pulse(clr_shutdown);
    chk("R4", "shutdown clears", alert_pin, 1'b1);

    // R11: clear coincident with a result
    cur_req = "R11";
    result(13'sh0100);
    res_valid = 1'b1; res_temp = 13'sh0100; clr_read = 1'b1; tick();
    res_valid = 1'b0; clr_read = 1'b0; tick();
    result(13'sh0600);
    chk("R11", "coincident result ignored", alert_pin, 1'b1);
    repeat (2) result(13'sh0100);
    chk("R11", "low alert after", alert_pin, 1'b0);

    // R9: general-call reset
    cur_req = "R9";
    pulse(gc_reset);
    chk("R9", "gc clears alert", alert_pin, 1'b1);
    chk("R9", "gc clears status", status_bit, 1'b1);
    intr_mode = 1'b0; tick(); intr_mode = 1'b1; tick();
    repeat (2) result(13'sh0100);
    chk("R9", "re-armed for high", alert_pin, 1'b1);

    // mixed random phase
    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      int h;
      if (i % 200 == 0) begin
        h = int'($urandom_range(4000)) - 2000;
        lim_hi = 13'(h);
        lim_lo = 13'(h - int'($urandom_range(200)));
        fq_sel = 2'($urandom_range(3));
        pol = 1'($urandom_range(1));
        intr_mode = 1'($urandom_range(1));
      end
      res_valid = ($urandom_range(2) != 0);
      res_temp = 13'(int'(lim_hi) - 300 + int'($urandom_range(400)));
      clr_read = ($urandom_range(15) == 0);
      clr_resp_won = ($urandom_range(31) == 0);
      clr_shutdown = ($urandom_range(31) == 0);
      gc_reset = ($urandom_range(127) == 0);
      tick();
    end
    res_valid = 0; clr_read = 0; clr_resp_won = 0; clr_shutdown = 0; gc_reset = 0;
    tick(); @(negedge clk); #1;
    finish_run();
  end
endmodule